// File: doc/BRIEF.md
# Two-Bit Branch Outcome Predictor

This block holds a direct-mapped table of 2-bit saturating counters that predicts whether a conditional branch will be taken. The fetch or decode stage places a branch address on the lookup port and gets a taken/not-taken guess in the same cycle, together with the raw counter behind it. When the branch resolves later in the pipeline, the execute stage reports its address and actual direction on the update port. The counter selected by that address then moves one step toward the observed outcome.

Each entry summarises the recent outcomes of every branch whose address maps to it. Because the counters have hysteresis, a branch that is almost always taken costs only one wrong guess at the single iteration where it falls through. A 1-bit table would cost two: one at the exit, and one more when the loop is entered again. The table has 512 entries by default and is indexed by nine address bits above the 4-byte instruction offset.

Top module: `two_bit_bht`

## Requirements
- R1: After a synchronous active-high reset, every entry holds counter value 2'b01 (weak not-taken), so every lookup reports `lk_ctr` = 1 and `lk_taken` = 0.
- R2: The entry index is address bits [10:2]. Bits [1:0] and all bits above bit 10 have no effect on which entry is read or written.
- R3: `lk_taken` is 1 exactly when the selected counter is 2'b10 or 2'b11 (its upper bit set). The states are 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R4: A valid update with `up_taken` = 1 raises the selected counter by one. A counter already at 2'b11 stays at 2'b11.
- R5: A valid update with `up_taken` = 0 lowers the selected counter by one. A counter already at 2'b00 stays at 2'b00.
- R6: Starting from a strong state, one outcome that contradicts the prediction leaves the prediction unchanged. A second contradicting outcome in a row reverses it.
- R7: While `up_valid` is 0, `up_pc` and `up_taken` change no entry.
- R8: The lookup output is combinational on `lk_pc`. When a lookup and an update select the same entry in one cycle, the lookup shows the value from before the update, and the new value appears from the next cycle.
- R9: An update changes only the entry it selects. All other entries keep their values.
- R10: For a loop branch that is taken several times and then not taken once, a warm table mispredicts exactly once per pass through the loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Prediction for `lk_pc`: 1 means taken |
| lk_ctr | output | 2 | Counter value selected by `lk_pc` |
| up_valid | input | 1 | Qualifies a resolved-branch update in this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The hardest case to reach is a lookup and an update landing on the same entry in the same cycle. The bench holds both ports on aliased addresses, samples the lookup after the inputs settle and before the clock edge, and samples again after the edge. The bench also sweeps every one of the 512 entries after reset and after scattered updates. This exposes an index mapping that is off by a bit or that leaks an update into a neighbouring entry. The hysteresis and saturation cases are driven from the strong states, where a single contradicting outcome must not reverse the prediction.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Upper counter bit carries the direction guess.
  function automatic logic ctr_predicts_taken(ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bht_pc_index.sv
module bht_pc_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 9,
  parameter int OFS_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);

  localparam int IDX_LO = OFS_W;
  localparam int IDX_HI = OFS_W + IDX_W - 1;

  assign idx = pc[IDX_HI:IDX_LO];

  logic unused_pc_bits;
  generate
    if (IDX_HI < PC_W - 1) begin : g_hi
      assign unused_pc_bits = ^{pc[PC_W-1:IDX_HI+1], pc[IDX_LO-1:0]};
    end else begin : g_nohi
      assign unused_pc_bits = ^pc[IDX_LO-1:0];
    end
  endgenerate

endmodule

// File: rtl/bht_ctr_update.sv
module bht_ctr_update
  import bht_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);

  always_comb begin
    unique case (cur)
      CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT   : CTR_STRONG_NT;
      CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T    : CTR_STRONG_NT;
      CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T  : CTR_WEAK_NT;
      default:       nxt = taken ? CTR_STRONG_T  : CTR_WEAK_T;
    endcase
  end

  always_comb begin
    if (taken) begin
      // R4
      sat_inc_chk: assert (int'(nxt) == ((int'(cur) == 3) ? 3 : int'(cur) + 1));
    end else begin
      // R5
      sat_dec_chk: assert (int'(nxt) == ((int'(cur) == 0) ? 0 : int'(cur) - 1));
    end
  end

endmodule

// File: rtl/bht_store.sv
module bht_store
  import bht_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx_a,
  output ctr_t             rd_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output ctr_t             rd_b,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  ctr_t             wdata
);

  localparam int ENTRIES = 1 << IDX_W;

  ctr_t mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= CTR_WEAK_NT;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  // Asynchronous read ports: both see the state from before this edge.
  assign rd_a = mem[rd_idx_a];
  assign rd_b = mem[rd_idx_b];

endmodule

// File: rtl/two_bit_bht.sv
module two_bit_bht
  import bht_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 9,
  parameter int OFS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [1:0]      lk_ctr,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);

  localparam int N_PORTS = 2;
  localparam int P_LK    = 0;
  localparam int P_UP    = 1;

  logic [PC_W-1:0]  port_pc  [N_PORTS];
  logic [IDX_W-1:0] port_idx [N_PORTS];

  assign port_pc[P_LK] = lk_pc;
  assign port_pc[P_UP] = up_pc;

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_idx
      bht_pc_index #(
        .PC_W (PC_W),
        .IDX_W(IDX_W),
        .OFS_W(OFS_W)
      ) u_idx (
        .pc (port_pc[p]),
        .idx(port_idx[p])
      );
    end
  endgenerate

  ctr_t lk_cur;
  ctr_t up_cur;
  ctr_t up_nxt;

  bht_store #(
    .IDX_W(IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_idx_a(port_idx[P_LK]),
    .rd_a    (lk_cur),
    .rd_idx_b(port_idx[P_UP]),
    .rd_b    (up_cur),
    .we      (up_valid),
    .widx    (port_idx[P_UP]),
    .wdata   (up_nxt)
  );

  bht_ctr_update u_upd (
    .cur  (up_cur),
    .taken(up_taken),
    .nxt  (up_nxt)
  );

  assign lk_ctr   = lk_cur;
  assign lk_taken = ctr_predicts_taken(lk_cur);

  logic same_idx;
  assign same_idx = (port_idx[P_LK] == port_idx[P_UP]);

  // R4
  inc_port_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_taken && same_idx && lk_ctr != 2'b11)
    |=> (!$stable(lk_pc) || lk_ctr == $past(lk_ctr) + 2'd1));

  // R5
  dec_port_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_taken && same_idx && lk_ctr != 2'b00)
    |=> (!$stable(lk_pc) || lk_ctr == $past(lk_ctr) - 2'd1));

  // R6
  hysteresis_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && same_idx && (lk_ctr[0] == lk_ctr[1]))
    |=> (!$stable(lk_pc) || lk_taken == $past(lk_taken)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_valid) |=> (!$stable(lk_pc) || $stable(lk_ctr)));

endmodule

// File: tb/tb_two_bit_bht.sv
`timescale 1ns/1ps
module tb_two_bit_bht;

  localparam int PC_W    = 32;
  localparam int IDX_W   = 9;
  localparam int ENTRIES = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] lk_pc;
  logic            lk_taken;
  logic [1:0]      lk_ctr;
  logic            up_valid;
  logic [PC_W-1:0] up_pc;
  logic            up_taken;

  always #2.5 clk = ~clk;

  two_bit_bht #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(2)) dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_ctr(lk_ctr),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int model [ENTRIES];
  bit done = 0;

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[10:2]);
  endfunction

  function automatic int step(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic logic [PC_W-1:0] pc_for(int idx, int hi, int lo);
    return (PC_W'(hi) << 11) | (PC_W'(idx) << 2) | PC_W'(lo & 3);
  endfunction

  task automatic check(string req, logic [PC_W-1:0] pc, int exp_ctr);
    lk_pc = pc;
    #0.5;
    n_cmp++;
    if (int'(lk_ctr) != exp_ctr || lk_taken !== (exp_ctr >= 2)) begin
      n_bad++;
      $display("FAIL %s pc=%h ctr=%0d taken=%0b expected ctr=%0d taken=%0b",
               req, pc, lk_ctr, lk_taken, exp_ctr, exp_ctr >= 2);
    end
  endtask

  // Drive one update at a negedge; it commits at the following posedge.
  task automatic update(logic [PC_W-1:0] pc, bit t);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
    model[idx_of(pc)] = step(model[idx_of(pc)], t);
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < ENTRIES; i++) check(req, pc_for(i, i * 7, i), model[i]);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lk_pc = '0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
    for (int i = 0; i < ENTRIES; i++) model[i] = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every entry weak not-taken after reset
    sweep("R1");

    // R3/R4: climb and saturate at strong taken on entry 5
    for (int k = 0; k < 4; k++) begin
      update(pc_for(5, 0, 0), 1'b1);
      check("R4", pc_for(5, 0, 0), model[5]);
    end
    // R6: one contradiction keeps taken, second flips
    update(pc_for(5, 0, 0), 1'b0);
    check("R6", pc_for(5, 0, 0), 2);
    update(pc_for(5, 0, 0), 1'b0);
    check("R6", pc_for(5, 0, 0), 1);
    // R5: descend and saturate at strong not-taken
    for (int k = 0; k < 3; k++) begin
      update(pc_for(5, 0, 0), 1'b0);
      check("R5", pc_for(5, 0, 0), model[5]);
    end
    // R6 from strong not-taken
    update(pc_for(5, 0, 0), 1'b1);
    check("R6", pc_for(5, 0, 0), 1);
    update(pc_for(5, 0, 0), 1'b1);
    check("R6", pc_for(5, 0, 0), 2);

    // R2: aliases via high and offset bits hit the same entry
    update(pc_for(300, 12345, 3), 1'b1);
    check("R2", pc_for(300, 99, 1), 2);
    check("R2", pc_for(300, 0, 0), 2);
    check("R2", pc_for(301, 12345, 3), 1);
    check("R2", pc_for(299, 12345, 3), 1);

    // R7: update fields toggling with valid low change nothing
    lk_pc = pc_for(300, 0, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      up_valid = 1'b0; up_pc = pc_for(300, k, k); up_taken = k[0];
    end
    @(negedge clk);
    check("R7", pc_for(300, 0, 0), 2);

    // R8: same-cycle lookup and update on entry 77
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc_for(77, 5, 2); up_taken = 1'b1;
    check("R8", pc_for(77, 1, 0), 1);
    @(negedge clk);
    up_valid = 1'b0;
    model[77] = 2;
    check("R8", pc_for(77, 1, 0), 2);

    // R9: scattered updates, then full sweep against model
    for (int k = 0; k < 40; k++)
      update(pc_for((k * 37 + 11) % ENTRIES, k, k), (k % 3) != 0);
    sweep("R9");

    // R10: loop taken 7 times then exits, 6 passes
    begin
      logic [PC_W-1:0] lp = pc_for(450, 3, 0);
      for (int pass = 0; pass < 6; pass++) begin
        int miss = 0;
        for (int it = 0; it < 8; it++) begin
          bit actual = (it != 7);
          lk_pc = lp;
          #0.5;
          if (lk_taken != actual) miss++;
          update(lp, actual);
        end
        if (pass >= 1) begin
          n_cmp++;
          if (miss != 1) begin
            n_bad++;
            $display("FAIL R10 pass=%0d mispredicts=%0d expected=1", pass, miss);
          end
        end
      end
      check("R10", lp, model[450]);
    end

    // R1: reset again restores every entry
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < ENTRIES; i++) model[i] = 1;
    sweep("R1");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule